// File: doc/BRIEF.md
# Headset Button Debounce Monitor

This block watches one raw headset-button line and turns it into a clean status bit. The raw level is brought into the local clock domain through a short flip-flop chain. It is then debounced by counting pulses of a slow reference tick. The debounced state changes only after the new level has stayed unchanged for a full debounce window, which defaults to 50 ticks (50 ms with a 1 ms tick).

The status output can follow the debounced level directly (follow mode). It can also present a sticky "pressed" flag (sticky mode), which holds after the button is let go until software clears it. An invert control flips the sense of the output. The line is active low: a low input is a pressed button and a high input is a released one.

The block is meant to sit in an always-on domain. It needs only its clock, its tick and its enable to keep working, so it stays live while the rest of the system is powered down. The register bus is not part of the block. The sticky flag is read on `flag_o` and cleared through a plain write strobe.

Top module: `hsbtn_monitor`

## Requirements
- R1: After reset, `stat_o` is 0 and `flag_o` is 0.
- R2: In follow mode (`sticky_mode_i` = 0) with `invert_i` = 0, a low level on `btn_n_i` that stays stable for at least `DEBOUNCE_TICKS` reference ticks drives `stat_o` to 1.
- R3: The debounce count restarts whenever the synchronized input changes. A level that lasts fewer than `DEBOUNCE_TICKS` ticks never reaches the debounced state or `stat_o`.
- R4: A release (high level) is debounced the same way as a press. After `DEBOUNCE_TICKS` stable ticks, `stat_o` returns to 0 in follow mode.
- R5: Every debounced press sets the sticky flag (`flag_o` = 1). In sticky mode (`sticky_mode_i` = 1), `stat_o` shows the flag, so it stays at 1 after the button is released.
- R6: A write with `flag_wr_i` = 1 and `flag_wdata_i` = 0 clears the sticky flag. A write of 1 leaves the flag unchanged.
- R7: When a clear write and a new debounced press fall in the same cycle, the flag is set.
- R8: With `invert_i` = 1, a pressed state appears as 0 on `stat_o` and a released state appears as 1.
- R9: While `enable_i` = 0, the debounced state is forced to released and `stat_o` shows the released value for the current polarity (equal to `invert_i`). After re-enable, a held press needs a full debounce window before it shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle reference tick pulse that times the debounce window |
| enable_i | input | 1 | Function enable |
| sticky_mode_i | input | 1 | 0: follow mode, 1: sticky mode |
| invert_i | input | 1 | 1 inverts the output sense |
| btn_n_i | input | 1 | Raw button line, low = pressed |
| flag_wr_i | input | 1 | Write strobe for the sticky flag |
| flag_wdata_i | input | 1 | Write data; 0 clears the flag |
| flag_o | output | 1 | Sticky pressed flag (read port) |
| stat_o | output | 1 | Registered button status output |

## Verification
The bench targets four weak spots:
- A glitchy press made of sub-window low pulses split by short highs. A counter that does not restart on a level change would add these up and report a press that never held.
- A release after a latched press in sticky mode. A mux that shows the live level instead of the flag would drop the output at once.
- A clear strobe held across the cycle a press completes. If clear wins over set, the press event is lost and the flag is never seen high.
- Disabling while the button is held down. A design that keeps its debounced state would still report pressed, and after re-enable it would skip the fresh debounce window.

// File: rtl/hsbtn_pkg.sv
package hsbtn_pkg;
  typedef enum logic {
    MODE_FOLLOW = 1'b0,
    MODE_STICKY = 1'b1
  } hsbtn_mode_e;

  typedef struct packed {
    logic pressed;
    logic press_evt;
  } hsbtn_deb_t;
endpackage

// File: rtl/hsbtn_sync.sv
module hsbtn_sync #(
  parameter int STAGES   = 2,
  parameter bit RST_LVL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= RST_LVL;
    else     chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[g] <= RST_LVL;
      else     chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hsbtn_debounce.sv
module hsbtn_debounce
  import hsbtn_pkg::*;
#(
  parameter int LIMIT = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       level_n_i,
  output hsbtn_deb_t deb_o
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic             smp;
  logic             prev_q;
  logic             state_q;
  logic             evt_q;
  logic [CNT_W-1:0] cnt_q;

  assign smp = ~level_n_i;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      prev_q  <= smp;
      state_q <= 1'b0;
      evt_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      prev_q <= smp;
      evt_q  <= 1'b0;
      if (smp != prev_q || smp == state_q) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == LAST) begin
          state_q <= smp;
          evt_q   <= smp;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign deb_o.pressed   = state_q;
  assign deb_o.press_evt = evt_q;
endmodule

// File: rtl/hsbtn_outsel.sv
module hsbtn_outsel
  import hsbtn_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en_i,
  input  hsbtn_mode_e mode_i,
  input  logic        invert_i,
  input  hsbtn_deb_t  deb_i,
  input  logic        wr_i,
  input  logic        wdata_i,
  output logic        flag_o,
  output logic        stat_o
);
  logic flag_q;
  logic stat_q;
  logic shown;

  always_ff @(posedge clk) begin
    if (rst)                   flag_q <= 1'b0;
    else if (deb_i.press_evt)  flag_q <= 1'b1;
    else if (wr_i && !wdata_i) flag_q <= 1'b0;
  end

  always_comb begin
    if (!en_i)                    shown = 1'b0;
    else if (mode_i == MODE_STICKY) shown = flag_q;
    else                          shown = deb_i.pressed;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= 1'b0;
    else     stat_q <= shown ^ invert_i;
  end

  assign flag_o = flag_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/hsbtn_monitor.sv
module hsbtn_monitor
  import hsbtn_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 50,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic enable_i,
  input  logic sticky_mode_i,
  input  logic invert_i,
  input  logic btn_n_i,
  input  logic flag_wr_i,
  input  logic flag_wdata_i,
  output logic flag_o,
  output logic stat_o
);
  logic        btn_n_sync;
  hsbtn_deb_t  deb;
  hsbtn_mode_e mode;
  logic        state_q;
  logic        press_evt;
  logic        flag_q;

  assign mode = hsbtn_mode_e'(sticky_mode_i);

  hsbtn_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (btn_n_i),
    .q_o (btn_n_sync)
  );

  hsbtn_debounce #(.LIMIT(DEBOUNCE_TICKS)) u_deb (
    .clk       (clk),
    .rst       (rst),
    .en_i      (enable_i),
    .tick_i    (tick_i),
    .level_n_i (btn_n_sync),
    .deb_o     (deb)
  );

  hsbtn_outsel u_out (
    .clk      (clk),
    .rst      (rst),
    .en_i     (enable_i),
    .mode_i   (mode),
    .invert_i (invert_i),
    .deb_i    (deb),
    .wr_i     (flag_wr_i),
    .wdata_i  (flag_wdata_i),
    .flag_o   (flag_q),
    .stat_o   (stat_o)
  );

  assign state_q   = deb.pressed;
  assign press_evt = deb.press_evt;
  assign flag_o    = flag_q;
endmodule

// File: rtl/hsbtn_monitor_chk.sv
module hsbtn_monitor_chk (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic enable_i,
  input logic invert_i,
  input logic flag_wr_i,
  input logic flag_wdata_i,
  input logic stat_o,
  input logic state_q,
  input logic press_evt,
  input logic flag_q
);
  // R9: disabled output equals the released value for the polarity
  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (stat_o == $past(invert_i)));

  // R7: a press event always leaves the flag set
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    press_evt |=> flag_q);

  // R6: a clear write without a press clears the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_wr_i && !flag_wdata_i && !press_evt) |=> !flag_q);

  // R5: the flag holds unless cleared
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(flag_wr_i && !flag_wdata_i)) |=> flag_q);

  // R5: the flag rises only after a press event
  p_flag_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(press_evt));

  // R3: the debounced state moves only on a tick
  p_state_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (enable_i && !tick_i) |=> $stable(state_q));
endmodule

bind hsbtn_monitor hsbtn_monitor_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .tick_i       (tick_i),
  .enable_i     (enable_i),
  .invert_i     (invert_i),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i),
  .stat_o       (stat_o),
  .state_q      (state_q),
  .press_evt    (press_evt),
  .flag_q       (flag_q)
);

// File: tb/hsbtn_monitor_tb_top.sv
`timescale 1ns/1ps
module hsbtn_monitor_tb_top;
  localparam int LIMIT = 6;
  localparam int TDIV  = 4;
  localparam int SHORT = (LIMIT - 2) * TDIV;
  localparam int LONG  = (LIMIT + 2) * TDIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic enable_i = 1'b0;
  logic sticky_mode_i = 1'b0;
  logic invert_i = 1'b0;
  logic btn_n_i = 1'b1;
  logic flag_wr_i = 1'b0;
  logic flag_wdata_i = 1'b0;
  logic flag_o;
  logic stat_o;

  int checks = 0;
  int fails = 0;
  logic seen_stat_hi = 1'b0;
  logic seen_flag_hi = 1'b0;

  always #2 clk = ~clk;

  hsbtn_monitor #(.DEBOUNCE_TICKS(LIMIT), .SYNC_STAGES(2)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (tick_i),
    .enable_i      (enable_i),
    .sticky_mode_i (sticky_mode_i),
    .invert_i      (invert_i),
    .btn_n_i       (btn_n_i),
    .flag_wr_i     (flag_wr_i),
    .flag_wdata_i  (flag_wdata_i),
    .flag_o        (flag_o),
    .stat_o        (stat_o)
  );

  initial begin
    forever begin
      for (int k = 0; k < TDIV; k++) begin
        @(negedge clk);
        tick_i = (k == TDIV - 1);
      end
    end
  end

  always @(negedge clk) begin
    if (stat_o) seen_stat_hi <= 1'b1;
    if (flag_o) seen_flag_hi <= 1'b1;
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_write(input logic v);
    flag_wr_i = 1'b1; flag_wdata_i = v;
    cyc(1);
    flag_wr_i = 1'b0; flag_wdata_i = 1'b0;
    cyc(2);
  endtask

  task automatic t_reset;
    cyc(1);
    check("R1 stat", stat_o, 1'b0);
    check("R1 flag", flag_o, 1'b0);
    rst = 1'b0; enable_i = 1'b1;
    cyc(2);
  endtask

  task automatic t_follow;
    btn_n_i = 1'b0;
    cyc(SHORT);
    check("R3 early", stat_o, 1'b0);
    cyc(LONG - SHORT);
    check("R2 press", stat_o, 1'b1);
    check("R5 flag set", flag_o, 1'b1);
    btn_n_i = 1'b1;
    cyc(SHORT);
    check("R4 early", stat_o, 1'b1);
    cyc(LONG - SHORT);
    check("R4 release", stat_o, 1'b0);
    sw_write(1'b0);
  endtask

  task automatic t_bounce;
    @(negedge clk); seen_stat_hi = 1'b0;
    for (int i = 0; i < 4; i++) begin
      btn_n_i = 1'b0; cyc(SHORT);
      btn_n_i = 1'b1; cyc(TDIV + 1);
    end
    cyc(4);
    check("R3 bounce", seen_stat_hi, 1'b0);
    check("R3 bounce flag", flag_o, 1'b0);
  endtask

  task automatic t_sticky;
    sticky_mode_i = 1'b1;
    cyc(2);
    check("R5 idle", stat_o, 1'b0);
    btn_n_i = 1'b0; cyc(LONG);
    check("R5 press", stat_o, 1'b1);
    btn_n_i = 1'b1; cyc(LONG);
    check("R5 held", stat_o, 1'b1);
    sw_write(1'b1);
    check("R6 write1", flag_o, 1'b1);
    check("R6 write1 stat", stat_o, 1'b1);
    sw_write(1'b0);
    check("R6 clear", flag_o, 1'b0);
    check("R6 clear stat", stat_o, 1'b0);
  endtask

  task automatic t_set_wins;
    flag_wr_i = 1'b1; flag_wdata_i = 1'b0;
    @(negedge clk); seen_flag_hi = 1'b0;
    btn_n_i = 1'b0; cyc(LONG);
    check("R7 set wins", seen_flag_hi, 1'b1);
    flag_wr_i = 1'b0;
    btn_n_i = 1'b1; cyc(LONG);
    sw_write(1'b0);
    sticky_mode_i = 1'b0;
    cyc(2);
  endtask

  task automatic t_polarity;
    invert_i = 1'b1; cyc(2);
    check("R8 released", stat_o, 1'b1);
    btn_n_i = 1'b0; cyc(LONG);
    check("R8 pressed", stat_o, 1'b0);
    btn_n_i = 1'b1; cyc(LONG);
    check("R8 back", stat_o, 1'b1);
    invert_i = 1'b0; cyc(2);
  endtask

  task automatic t_disable;
    btn_n_i = 1'b0; cyc(LONG);
    check("R9 pre", stat_o, 1'b1);
    enable_i = 1'b0; cyc(3);
    check("R9 off", stat_o, 1'b0);
    invert_i = 1'b1; cyc(2);
    check("R9 off inv", stat_o, 1'b1);
    invert_i = 1'b0; cyc(LONG);
    check("R9 held off", stat_o, 1'b0);
    enable_i = 1'b1; cyc(SHORT);
    check("R9 re-enable early", stat_o, 1'b0);
    cyc(LONG - SHORT);
    check("R9 re-enable late", stat_o, 1'b1);
    btn_n_i = 1'b1; cyc(LONG);
  endtask

  initial begin
    t_reset();
    t_follow();
    t_bounce();
    t_sticky();
    t_set_wins();
    t_polarity();
    t_disable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule